// File: doc/BRIEF.md
# Blinking Warning Sign Sequencer

This block sequences the lamps of a five-lamp warning sign. While the operate switch input is high, the block steps through four lighting phases, one phase per clock edge. It starts dark, then lights lamps 1 and 2. Next it adds lamps 3 and 4, and then it adds lamp 5. After that it returns to dark, and the cycle repeats for as long as the switch stays on. When the switch input goes low, the next clock edge sends the sign back to dark, however far the pattern had got.

The phase is held in a two-bit register. The three lamp-group enables are decoded from that register only, so the block is a Moore machine: the switch input reaches the lamps only through a clock edge. The block is meant to be clocked at the blink rate that the surrounding logic chooses.

Top module: `blink_sign_seq`

## Requirements
- R1: When `rst` is high at a clock edge, the phase becomes 00 and all three lamp enables read 0 after that edge.
- R2: While `run_en` is high, each clock edge advances the phase in the order 00, 01, 10, 11, 00, and this order repeats for as long as `run_en` stays high.
- R3: When `run_en` is low at a clock edge, the phase becomes 00 (all lamps off) after that edge, from any of the four phases.
- R4: `lamp12_on` is 1 in phases 01, 10 and 11, and 0 in phase 00.
- R5: `lamp34_on` is 1 only in phases 10 and 11.
- R6: `lamp5_on` is 1 only in phase 11.
- R7: The lamp enables depend only on the stored phase: changing `run_en` between clock edges leaves all three outputs unchanged until the next edge.
- R8: At the first clock edge after `run_en` rises from low to high, the outputs become `lamp12_on`=1, `lamp34_on`=0, `lamp5_on`=0.
- R9: The lamps light cumulatively: `lamp5_on` implies `lamp34_on`, and `lamp34_on` implies `lamp12_on`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every phase change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Operate switch; high lets the sequence run, low sends the sign dark at the next edge |
| lamp12_on | output | 1 | Enable for lamps 1 and 2 |
| lamp34_on | output | 1 | Enable for lamps 3 and 4 |
| lamp5_on | output | 1 | Enable for lamp 5 |

## Verification
The switch is first held high for several full rounds, which shows that the phase order and the wrap from 11 back to 00 are correct. A stretch with the switch on is then followed by a drop from each of the four phases. This shows that the return to dark does not depend on the phase it starts from. The switch is also toggled between clock edges, which would expose any path from the switch to the lamps that bypasses the register. A long pseudo-random on/off pattern is checked cycle by cycle against an arithmetic model in the bench. This pattern covers restarts at every phase and rising switch edges at varying points.

// File: rtl/blink_sign_pkg.sv
package blink_sign_pkg;
  // Number of lamp groups that light cumulatively.
  localparam int GROUP_COUNT = 3;
  // One dark phase plus one phase per group.
  localparam int PHASE_COUNT = GROUP_COUNT + 1;
  localparam int PHASE_W     = $clog2(PHASE_COUNT);

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PHASE_DARK = '0;
  localparam phase_t PHASE_LAST = phase_t'(PHASE_COUNT - 1);
endpackage

// File: rtl/sign_phase_next.sv
module sign_phase_next #(
  parameter int PHASES = 4,
  localparam int W = $clog2(PHASES)
) (
  input  logic [W-1:0] cur,
  input  logic         run,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] LAST = W'(PHASES - 1);

  always_comb begin
    if (!run || cur == LAST) nxt = '0;
    else                     nxt = cur + 1'b1;
  end
endmodule

// File: rtl/sign_phase_reg.sv
module sign_phase_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/sign_lamp_decode.sv
module sign_lamp_decode #(
  parameter int GROUPS = 3,
  localparam int W = $clog2(GROUPS + 1)
) (
  input  logic [W-1:0]      phase,
  output logic [GROUPS-1:0] lamps
);
  // Thermometer decode: group g is lit once the phase passes g.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign lamps[g] = (phase > W'(g));
  end

  // R9: each outer group implies every inner group.
  always_comb begin
    if (!$isunknown(lamps)) begin
      for (int g = 1; g < GROUPS; g++) begin
        p_nested_r9: assert (!lamps[g] || lamps[g-1])
          else $error("lamp group %0d lit without group %0d", g, g - 1);
      end
    end
  end
endmodule

// File: rtl/blink_sign_seq.sv
module blink_sign_seq
  import blink_sign_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic lamp12_on,
  output logic lamp34_on,
  output logic lamp5_on
);
  phase_t                 phase_q;
  phase_t                 phase_d;
  logic [GROUP_COUNT-1:0] lamps;

  sign_phase_next #(.PHASES(PHASE_COUNT)) u_next (
    .cur (phase_q),
    .run (run_en),
    .nxt (phase_d)
  );

  sign_phase_reg #(.W(PHASE_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (phase_d),
    .q   (phase_q)
  );

  sign_lamp_decode #(.GROUPS(GROUP_COUNT)) u_dec (
    .phase (phase_q),
    .lamps (lamps)
  );

  assign lamp12_on = lamps[0];
  assign lamp34_on = lamps[1];
  assign lamp5_on  = lamps[2];

  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> (lamps == '0));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && phase_q != PHASE_LAST) |=> (phase_q == phase_t'($past(phase_q) + 1'b1)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && phase_q == PHASE_LAST) |=> (phase_q == PHASE_DARK));

  p_clear_on_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (phase_q == PHASE_DARK));

  p_lamp5_top_only_r6: assert property (@(posedge clk) disable iff (rst)
    lamp5_on |-> (phase_q == PHASE_LAST));

  p_first_lit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |=> (lamp12_on && !lamp34_on && !lamp5_on));
endmodule

// File: tb/tb_blink_sign_seq.sv
module tb_blink_sign_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic lamp12_on, lamp34_on, lamp5_on;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 1'b0;

  blink_sign_seq dut (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .lamp12_on (lamp12_on),
    .lamp34_on (lamp34_on),
    .lamp5_on  (lamp5_on)
  );

  always #5 clk = ~clk;

  function automatic logic [2:0] exp_lamps(input int s);
    return {s >= 3, s >= 2, s >= 1};
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  // One clock edge; the model follows R1/R2/R3 arithmetically.
  task automatic tick;
    @(posedge clk);
    if (rst)         model = 0;
    else if (run_en) model = (model + 1) % 4;
    else             model = 0;
    #2;
  endtask

  function automatic logic [2:0] lamps_now();
    return {lamp5_on, lamp34_on, lamp12_on};
  endfunction

  initial begin
    logic [7:0] lfsr;
    int prev;
    tick; tick;
    check("R1 reset dark", lamps_now(), 3'b000);
    rst = 1'b0;
    tick;
    check("R3 idle stays dark", lamps_now(), 3'b000);

    // R2, R4, R5, R6, R8: full rounds with the switch held on.
    run_en = 1'b1;
    tick;
    check("R8 first lit phase", lamps_now(), 3'b001);
    for (int i = 0; i < 12; i++) begin
      tick;
      check("R2/R4/R5/R6 run sequence", lamps_now(), exp_lamps(model));
    end

    // R3: drop the switch from each of the four phases.
    for (int s = 0; s < 4; s++) begin
      run_en = 1'b0;
      tick;
      run_en = 1'b1;
      for (int k = 0; k < s; k++) tick;
      check("R2 reached phase", lamps_now(), exp_lamps(s));
      run_en = 1'b0;
      tick;
      check("R3 drop forces dark", lamps_now(), 3'b000);
    end

    // R7: toggle the switch between edges in every phase.
    run_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      tick;
      run_en = 1'b0;
      #1;
      check("R7 no change between edges", lamps_now(), exp_lamps(model));
      run_en = 1'b1;
      #1;
      check("R7 no change between edges", lamps_now(), exp_lamps(model));
    end

    // R1: reset taken from a lit phase.
    run_en = 1'b1;
    tick; tick;
    rst = 1'b1;
    tick;
    check("R1 reset from lit phase", lamps_now(), 3'b000);
    rst = 1'b0;

    // Pseudo-random switch pattern against the model (R2, R3, R8, R9).
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      prev = run_en;
      run_en = lfsr[0] | lfsr[1];
      tick;
      if (run_en && prev == 0)
        check("R8 restart lit phase", lamps_now(), 3'b001);
      else
        check("R2/R3 sweep", lamps_now(), exp_lamps(model));
      checks++;
      if ((lamp5_on && !lamp34_on) || (lamp34_on && !lamp12_on)) begin
        errors++;
        $display("FAIL R9 nesting got %b expected cumulative", lamps_now());
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule